// File: doc/BRIEF.md
# Chained DMA Descriptor Loader

This block refills one DMA channel from a linked list of descriptors kept in memory. When the channel asks for its next descriptor, the loader takes the current descriptor pointer and derives a 16-byte aligned fetch address. If the pointer's branch-enable bit is set and the channel's compare-status flag is up, it moves the fetch address on by 32 bytes to an alternate descriptor. It then reads four consecutive words through a simple word-read memory master. The words fill the channel's next-pointer, source, target and command registers.

Once the command word arrives, the loaded fields are post-processed. A source or target address that is flow-controlled by a peripheral is forced to word alignment. A one-cycle start-status pulse is raised if the command enables the start interrupt. A single-cycle done pulse marks the end of the load, and an end-of-chain output reflects bit 0 of the freshly loaded next pointer. Moving data and combining interrupts belong to other blocks.

Top module: `dma_desc_loader`

## Requirements
- R1: The first read of a load goes to `cur_ptr` with bits 3:0 cleared, whenever the branch is not taken.
- R2: When `cur_ptr` bit 1 and `cmp_flag` are both 1 at the request, 32 is added to the aligned fetch address. If either of them is 0, no offset is added.
- R3: A load issues exactly four reads at the base address, base+4, base+8 and base+12, in that order. Only one read is offered at a time. While `mem_valid` is high and `mem_ready` is low, `mem_addr` holds steady.
- R4: A read completes in the cycle where `mem_valid` and `mem_ready` are both high, and `mem_rdata` is taken in that cycle. The four words go, in order, to `chan_next`, `chan_src`, `chan_dst` and `chan_cmd`.
- R5: If command bit 29 is 1, `chan_src` bits 1:0 read 0 after the load. Otherwise the loaded source word is kept unchanged.
- R6: If command bit 28 is 1, `chan_dst` bits 1:0 read 0 after the load. Otherwise the loaded target word is kept unchanged.
- R7: `start_set` pulses high together with `done` when command bit 22 is 1, and stays low otherwise.
- R8: `chain_end` equals bit 0 of the loaded next-descriptor word.
- R9: `busy` goes high in the cycle after an accepted request. `done` goes high for exactly one cycle, in the cycle after the fourth read completes. In that cycle all channel registers already hold their new values, `busy` is low and no read is offered.
- R10: `fetch_req` is ignored while a load is in progress. The ongoing load keeps its addresses and still makes exactly four reads.
- R11: After reset, `mem_valid`, `busy`, `done`, `start_set` and `chain_end` are low, and all channel registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Request to load the next descriptor |
| cur_ptr | input | 32 | Current descriptor pointer (bit 1 = branch enable) |
| cmp_flag | input | 1 | Channel compare-status flag |
| mem_addr | output | 32 | Read word address |
| mem_valid | output | 1 | Read request valid |
| mem_ready | input | 1 | Memory accepts the read; data returned the same cycle |
| mem_rdata | input | 32 | Read data |
| chan_next | output | 32 | Loaded next-descriptor pointer |
| chan_src | output | 32 | Loaded source address |
| chan_dst | output | 32 | Loaded target address |
| chan_cmd | output | 32 | Loaded command word |
| chain_end | output | 1 | Bit 0 of the loaded next pointer |
| start_set | output | 1 | One-cycle start-status set pulse |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle load-complete pulse |

## Verification
The assertions assume a combinational memory: `mem_rdata` is valid for the address offered in any cycle where `mem_ready` is high. They also assume `cur_ptr` and `cmp_flag` are meaningful only in the cycle the request is taken. The bench models memory as a small word array read straight from `mem_addr`, so the data always matches the offered address. It changes `cur_ptr` only while idle, except in the case that deliberately re-requests during a load. It withdraws `fetch_req` before `done`, so that no second load is started by accident.

// File: rtl/dmadesc_pkg.sv
package dmadesc_pkg;
  typedef enum logic {ST_IDLE, ST_FETCH} load_st_e;

  // order in which descriptor words arrive
  localparam int WORD_NEXT = 0;
  localparam int WORD_SRC  = 1;
  localparam int WORD_DST  = 2;
  localparam int WORD_CMD  = 3;
  localparam int DESC_WORDS = 4;

  // control bit positions
  localparam int CMD_SRC_FLOW = 29;
  localparam int CMD_DST_FLOW = 28;
  localparam int CMD_START_IE = 22;
  localparam int PTR_BRANCH   = 1;
  localparam int PTR_LAST     = 0;
endpackage

// File: rtl/dmadesc_addr.sv
module dmadesc_addr #(
  parameter int W          = 32,
  parameter int ALIGN_BITS = 4,
  parameter int BRANCH_OFS = 32
) (
  input  logic [W-1:0] ptr,
  input  logic         cmp,
  output logic [W-1:0] base
);
  import dmadesc_pkg::*;

  logic         take_branch;
  logic [W-1:0] aligned;
  logic         unused_low;

  assign take_branch = ptr[PTR_BRANCH] & cmp;
  assign aligned     = {ptr[W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  assign base        = aligned + (take_branch ? W'(BRANCH_OFS) : '0);
  assign unused_low  = ^{ptr[PTR_LAST], ptr[ALIGN_BITS-1:2]};
endmodule

// File: rtl/dmadesc_seq.sv
module dmadesc_seq #(
  parameter int W      = 32,
  parameter int NWORDS = 4,
  localparam int IDXW  = $clog2(NWORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [W-1:0]    base,
  input  logic            mem_ready,
  output logic            mem_valid,
  output logic [W-1:0]    mem_addr,
  output logic            busy,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic            done
);
  import dmadesc_pkg::*;

  load_st_e        state_q, state_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic [W-1:0]    base_q, base_d;
  logic            done_q, done_d;
  logic            last_wr;
  logic            idx_en;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    base_d  = base_q;
    idx_en  = 1'b0;
    wr_en   = (state_q == ST_FETCH) && mem_ready;
    last_wr = wr_en && (idx_q == IDXW'(NWORDS - 1));
    done_d  = last_wr;
    case (state_q)
      ST_IDLE: begin
        if (req) begin
          base_d  = base;
          idx_d   = '0;
          idx_en  = 1'b1;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (wr_en) begin
          idx_d  = idx_q + 1'b1;
          idx_en = 1'b1;
          if (last_wr) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (idx_en) idx_q <= idx_d;
      if (state_q == ST_IDLE && req) base_q <= base_d;
    end
  end

  assign mem_valid = (state_q == ST_FETCH);
  assign mem_addr  = base_q + (W'(idx_q) << 2);
  assign busy      = (state_q == ST_FETCH);
  assign wr_idx    = idx_q;
  assign done      = done_q;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr))); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !last_wr) |=> (mem_valid && mem_addr == $past(mem_addr) + W'(4))); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_valid && !busy)); // R9
  AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && req) |=> (mem_valid && $stable(mem_addr))); // R10
endmodule

// File: rtl/dmadesc_regs.sv
module dmadesc_regs #(
  parameter int W      = 32,
  parameter int NWORDS = 4,
  localparam int IDXW  = $clog2(NWORDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDXW-1:0]           wr_idx,
  input  logic [W-1:0]              rdata,
  output logic [NWORDS-1:0][W-1:0]  words,
  output logic                      start_set
);
  import dmadesc_pkg::*;

  logic [NWORDS-1:0][W-1:0] word_q, word_d;
  logic [NWORDS-1:0]        word_en;
  logic                     cmd_wr;
  logic                     start_q, start_d;

  assign cmd_wr = wr_en && (wr_idx == IDXW'(WORD_CMD));

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_comb begin
      word_d[g]  = word_q[g];
      word_en[g] = 1'b0;
      if (wr_en && wr_idx == IDXW'(g)) begin
        word_d[g]  = rdata;
        word_en[g] = 1'b1;
      end
      if (g == WORD_SRC && cmd_wr && rdata[CMD_SRC_FLOW]) begin
        word_d[g][1:0] = 2'b00;
        word_en[g]     = 1'b1;
      end
      if (g == WORD_DST && cmd_wr && rdata[CMD_DST_FLOW]) begin
        word_d[g][1:0] = 2'b00;
        word_en[g]     = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          word_q[g] <= '0;
      else if (word_en[g]) word_q[g] <= word_d[g];
    end
  end

  assign start_d = cmd_wr && rdata[CMD_START_IE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_d;
  end

  assign words     = word_q;
  assign start_set = start_q;

  AST_NEXT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDXW'(WORD_NEXT)) |=> (words[WORD_NEXT] == $past(rdata))); // R4
  AST_SRC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && rdata[CMD_SRC_FLOW]) |=> (words[WORD_SRC][1:0] == 2'b00)); // R5
  AST_DST_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && rdata[CMD_DST_FLOW]) |=> (words[WORD_DST][1:0] == 2'b00)); // R6
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && rdata[CMD_START_IE]) |=> start_set); // R7
  AST_START_ONLY_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    start_set |-> $past(cmd_wr)); // R7
endmodule

// File: rtl/dma_desc_loader.sv
module dma_desc_loader #(
  parameter int W          = 32,
  parameter int ALIGN_BITS = 4,
  parameter int BRANCH_OFS = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fetch_req,
  input  logic [W-1:0] cur_ptr,
  input  logic         cmp_flag,
  output logic [W-1:0] mem_addr,
  output logic         mem_valid,
  input  logic         mem_ready,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] chan_next,
  output logic [W-1:0] chan_src,
  output logic [W-1:0] chan_dst,
  output logic [W-1:0] chan_cmd,
  output logic         chain_end,
  output logic         start_set,
  output logic         busy,
  output logic         done
);
  import dmadesc_pkg::*;

  localparam int NWORDS = DESC_WORDS;
  localparam int IDXW   = $clog2(NWORDS);

  logic [W-1:0]             base;
  logic                     wr_en;
  logic [IDXW-1:0]          wr_idx;
  logic [NWORDS-1:0][W-1:0] words;

  dmadesc_addr #(.W(W), .ALIGN_BITS(ALIGN_BITS), .BRANCH_OFS(BRANCH_OFS)) u_addr (
    .ptr  (cur_ptr),
    .cmp  (cmp_flag),
    .base (base)
  );

  dmadesc_seq #(.W(W), .NWORDS(NWORDS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (fetch_req),
    .base      (base),
    .mem_ready (mem_ready),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .busy      (busy),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .done      (done)
  );

  dmadesc_regs #(.W(W), .NWORDS(NWORDS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .rdata     (mem_rdata),
    .words     (words),
    .start_set (start_set)
  );

  assign chan_next = words[WORD_NEXT];
  assign chan_src  = words[WORD_SRC];
  assign chan_dst  = words[WORD_DST];
  assign chan_cmd  = words[WORD_CMD];
  assign chain_end = words[WORD_NEXT][PTR_LAST];

  AST_START_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start_set |-> done); // R7
  AST_FIRST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_valid)) |-> (mem_addr[ALIGN_BITS-1:0] == '0)); // R1
endmodule

// File: tb/dma_desc_loader_tb.sv
module dma_desc_loader_tb;
  logic        clk;
  logic        rst_n;
  logic        fetch_req;
  logic [31:0] cur_ptr;
  logic        cmp_flag;
  logic [31:0] mem_addr;
  logic        mem_valid;
  logic        mem_ready;
  logic [31:0] mem_rdata;
  logic [31:0] chan_next, chan_src, chan_dst, chan_cmd;
  logic        chain_end, start_set, busy, done;

  logic [31:0] mem [64];
  assign mem_rdata = mem[mem_addr[7:2]];

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit stall    = 0;
  bit finished = 0;
  int reads_seen = 0;

  logic [31:0] exp_addr[$];
  string       exp_tag[$];
  logic [31:0] exp_res[$];
  logic        exp_start[$];

  dma_desc_loader u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .cur_ptr(cur_ptr),
    .cmp_flag(cmp_flag), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .chan_next(chan_next),
    .chan_src(chan_src), .chan_dst(chan_dst), .chan_cmd(chan_cmd),
    .chain_end(chain_end), .start_set(start_set), .busy(busy), .done(done)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ready pattern, driven after the rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 mem_ready = stall ? ((cyc % 3) == 2) : 1'b1;
  end

  // monitor: address scoreboard and result scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      reads_seen++;
      if (exp_addr.size() == 0) check("R3 unexpected read", mem_addr, 32'hxxxx_xxxx);
      else check(exp_tag.pop_front(), mem_addr, exp_addr.pop_front());
    end
    if (rst_n && done) begin
      check("R10 reads per load", 32'(reads_seen), 32'd4);
      reads_seen = 0;
      if (exp_res.size() < 5) check("R9 unexpected done", 32'd1, 32'd0);
      else begin
        check("R4 next", chan_next, exp_res.pop_front());
        check("R5 src",  chan_src,  exp_res.pop_front());
        check("R6 dst",  chan_dst,  exp_res.pop_front());
        check("R4 cmd",  chan_cmd,  exp_res.pop_front());
        check("R8 chain_end", 32'(chain_end), exp_res.pop_front());
        check("R7 start_set", 32'(start_set), 32'(exp_start.pop_front()));
        check("R9 busy low at done", 32'(busy), 32'd0);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // driver: place a descriptor, push expectations, request, wait for done
  task automatic do_load(input logic [31:0] ptr, input logic cmp,
                         input logic [31:0] w0, input logic [31:0] w1,
                         input logic [31:0] w2, input logic [31:0] w3,
                         input bit use_stall, input bit rereq);
    logic [31:0] base;
    int guard;
    base = {ptr[31:4], 4'h0};
    if (ptr[1] && cmp) base = base + 32'd32;
    mem[base[7:2]]     = w0;
    mem[base[7:2] + 1] = w1;
    mem[base[7:2] + 2] = w2;
    mem[base[7:2] + 3] = w3;
    for (int i = 0; i < 4; i++) begin
      exp_addr.push_back(base + 32'(4 * i));
      if (i == 0) exp_tag.push_back((ptr[1] && cmp) ? "R2 branch base" : "R1 aligned base");
      else        exp_tag.push_back(rereq ? "R10 order under re-request" : "R3 sequential");
    end
    exp_res.push_back(w0);
    exp_res.push_back(w3[29] ? {w1[31:2], 2'b00} : w1);
    exp_res.push_back(w3[28] ? {w2[31:2], 2'b00} : w2);
    exp_res.push_back(w3);
    exp_res.push_back({31'd0, w0[0]});
    exp_start.push_back(w3[22]);
    stall = use_stall;
    @(posedge clk); #2;
    fetch_req = 1; cur_ptr = ptr; cmp_flag = cmp;
    @(posedge clk); #2;
    if (!rereq) fetch_req = 0;
    else begin
      cur_ptr = 32'h0000_0080; cmp_flag = 1;
    end
    @(negedge clk);
    check("R9 busy after request", 32'(busy), 32'd1);
    if (rereq) begin
      repeat (3) @(posedge clk);
      #2 fetch_req = 0;
    end
    guard = 0;
    while (!done && guard < 200) begin
      @(negedge clk); guard++;
    end
    check("R9 done seen", 32'(done), 32'd1);
    @(negedge clk);
    check("R9 done one cycle", 32'(done), 32'd0);
    check("R10 no restart", 32'(mem_valid), 32'd0);
    stall = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hA5A5_0000 | 32'(i);
    rst_n = 0; fetch_req = 0; cur_ptr = 0; cmp_flag = 0; mem_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 mem_valid", 32'(mem_valid), 32'd0);
    check("R11 busy", 32'(busy), 32'd0);
    check("R11 done", 32'(done), 32'd0);
    check("R11 chan_next", chan_next, 32'd0);
    check("R11 chan_cmd", chan_cmd, 32'd0);
    check("R11 start_set/chain_end", {30'd0, start_set, chain_end}, 32'd0);
    rst_n = 1;
    repeat (2) @(posedge clk);

    // plain, start irq enabled, no flow control
    do_load(32'h1000_0040, 1'b0, 32'h1000_0082, 32'h2000_0003, 32'h3000_0001, 32'h0040_0010, 0, 0);
    // branch taken, source flow control, stalled memory
    do_load(32'h1000_004B, 1'b1, 32'h1000_0010, 32'h2000_0103, 32'h3000_0202, 32'h2000_0020, 1, 0);
    // branch bit set but compare clear, target flow control
    do_load(32'h1000_0022, 1'b0, 32'h0000_0001, 32'h4000_0007, 32'h5000_0006, 32'h1040_0008, 0, 0);
    // compare set but branch bit clear, both flow controls, chain end
    do_load(32'h1000_0085, 1'b1, 32'h0000_0031, 32'h6000_000B, 32'h7000_000F, 32'h3000_0004, 1, 0);
    // request held during a stalled load must be ignored
    do_load(32'h1000_00C0, 1'b0, 32'h0000_0050, 32'h8000_0001, 32'h9000_0002, 32'h0000_0100, 1, 1);

    repeat (4) @(posedge clk);
    check("R3 scoreboard drained", 32'(exp_addr.size()), 32'd0);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule